// File: doc/BRIEF.md
# Row Cache Tag Directory

This block is the controller-side bookkeeping for a small on-chip cache whose lines are entire DRAM rows. It holds, for each line, a valid bit, the row tag, a modified flag and a recency rank. Every request is looked up against all stored tags at once. The block answers in the same cycle with hit or miss and a line index. On a hit, that index is the matching line. On a miss, it is the line chosen to receive the row.

Lines that have been modified are never chosen for replacement. A miss therefore never waits for the old row to be copied back. Instead, the oldest modified line is offered to a background copy-back engine. That engine reports completion through a done strobe and a line index, which clears the modified flag. If every line is valid and modified, a miss cannot be placed. The request is held off and a forced copy-back is requested.

Top module: `row_cache_directory`

## Requirements
- R1: After reset no line is valid and none is modified: `dirty_any` is 0 and the first request misses with `rsp_idx` = 0.
- R2: A request whose tag is held by a valid line gives `rsp_hit` = 1 and `rsp_idx` equal to the index of that line, in the same cycle.
- R3: On a miss while any line is invalid, the victim is the invalid line with the lowest index.
- R4: An accepted write that hits sets the modified flag of that line. A read hit leaves the flag unchanged.
- R5: On a miss when all lines are valid, the victim is the least recently used line among those not modified. A modified line is never a victim.
- R6: Every accepted hit or fill makes the line the most recently used. Recency ranks run from 0 (most recent) up to N_BLOCKS-1 (least recent).
- R7: A miss while every line is valid and modified gives `rsp_stall` = 1 and `force_wb` = 1. The request is not accepted and leaves valid bits, tags and recency unchanged.
- R8: `wb_done` with `wb_idx` clears the modified flag of that line at the next edge. If an accepted write to the same line falls in the same cycle, the write wins and the line stays modified.
- R9: `dirty_any` is 1 exactly when some line is modified. `dirty_idx` then gives the least recently used modified line.
- R10: An accepted read miss fills the victim as clean. An accepted write miss fills it and marks it modified in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A lookup request is present this cycle |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_tag | input | TAG_W | Row tag of the request |
| wb_done | input | 1 | Copy-back of one line has completed |
| wb_idx | input | IDX_W | Line whose copy-back completed |
| rsp_hit | output | 1 | Request tag found in a valid line |
| rsp_idx | output | IDX_W | Hit line, or victim line on a miss |
| rsp_stall | output | 1 | Miss cannot be placed; request not accepted |
| force_wb | output | 1 | Request to copy back the oldest modified line now |
| dirty_any | output | 1 | At least one line is modified |
| dirty_idx | output | IDX_W | Least recently used modified line |

## Verification
The hardest state to reach is a full directory in which every line is modified while a miss arrives. That is the only case that stalls, and the only one where a completion and a write meet on one line. The stimulus fills all lines and then writes to each of them. It then presents a fresh tag and holds it across stalled cycles until a completion frees the oldest modified line. After that it clears every line, then writes to a line and completes it in the same cycle. A pseudo-random phase over a tag pool larger than the directory follows, with completions fed back from `dirty_idx`. All of this is compared against a timestamp-ordered reference model.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
   // index width for a given line count, never below one bit
   function automatic int idx_width(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rcd_tag_match.sv
module rcd_tag_match #(
   parameter int N_BLOCKS = 16,
   parameter int TAG_W    = 20
) (
   input  logic [N_BLOCKS-1:0]       valid_i,
   input  logic [N_BLOCKS*TAG_W-1:0] tags_i,
   input  logic [TAG_W-1:0]          tag_i,
   output logic [N_BLOCKS-1:0]       match_o
);
   for (genvar g = 0; g < N_BLOCKS; g++) begin : g_cmp
      assign match_o[g] = valid_i[g] && (tags_i[g*TAG_W +: TAG_W] == tag_i);
   end
endmodule

// File: rtl/rcd_oldest_pick.sv
module rcd_oldest_pick #(
   parameter int N_BLOCKS = 16,
   parameter int AGE_W    = 4
) (
   input  logic [N_BLOCKS-1:0]       cand_i,
   input  logic [N_BLOCKS*AGE_W-1:0] age_i,
   output logic                      found_o,
   output logic [AGE_W-1:0]          idx_o
);
   logic [AGE_W-1:0] best_age;

   always_comb begin
      found_o  = 1'b0;
      idx_o    = '0;
      best_age = '0;
      for (int i = 0; i < N_BLOCKS; i++) begin
         if (cand_i[i] && (!found_o || age_i[i*AGE_W +: AGE_W] > best_age)) begin
            found_o  = 1'b1;
            idx_o    = AGE_W'(i);
            best_age = age_i[i*AGE_W +: AGE_W];
         end
      end
   end
endmodule

// File: rtl/rcd_age_rank.sv
module rcd_age_rank #(
   parameter int N_BLOCKS = 16,
   parameter int AGE_W    = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      touch_i,
   input  logic [AGE_W-1:0]          touch_idx_i,
   output logic [N_BLOCKS*AGE_W-1:0] age_o
);
   logic [AGE_W-1:0]    age_q [N_BLOCKS];
   logic [AGE_W-1:0]    sel_age;
   logic [N_BLOCKS-1:0] mru_vec;

   assign sel_age = age_q[touch_idx_i];

   for (genvar g = 0; g < N_BLOCKS; g++) begin : g_rank
      assign age_o[g*AGE_W +: AGE_W] = age_q[g];
      assign mru_vec[g]              = (age_q[g] == '0);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            age_q[g] <= AGE_W'(g);
         end else if (touch_i) begin
            if (touch_idx_i == AGE_W'(g))
               age_q[g] <= '0;
            else if (age_q[g] < sel_age)
               age_q[g] <= age_q[g] + 1'b1;
         end
      end
   end

   AST_ONE_MRU: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(mru_vec));                                                   // R6
   AST_TOUCH_MRU: assert property (@(posedge clk) disable iff (!rst_n)
      touch_i |=> (age_q[$past(touch_idx_i)] == '0));                      // R6
endmodule

// File: rtl/row_cache_directory.sv
module row_cache_directory #(
   parameter int N_BLOCKS = 16,
   parameter int TAG_W    = 20,
   localparam int IDX_W   = rcd_pkg::idx_width(N_BLOCKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [TAG_W-1:0] req_tag,
   input  logic             wb_done,
   input  logic [IDX_W-1:0] wb_idx,
   output logic             rsp_hit,
   output logic [IDX_W-1:0] rsp_idx,
   output logic             rsp_stall,
   output logic             force_wb,
   output logic             dirty_any,
   output logic [IDX_W-1:0] dirty_idx
);
   if (N_BLOCKS < 2) begin : g_bad_n
      $error("N_BLOCKS must be at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("TAG_W must be at least 1");
   end

   logic [N_BLOCKS-1:0]       valid_q, dirty_q, match;
   logic [TAG_W-1:0]          tag_q [N_BLOCKS];
   logic [N_BLOCKS*TAG_W-1:0] tags_flat;
   logic [N_BLOCKS*IDX_W-1:0] ages;
   logic [IDX_W-1:0]          hit_idx, inv_idx, clean_idx, victim_idx;
   logic                      any_inv, clean_found, have_victim, accept;

   for (genvar g = 0; g < N_BLOCKS; g++) begin : g_flat
      assign tags_flat[g*TAG_W +: TAG_W] = tag_q[g];
   end

   rcd_tag_match #(.N_BLOCKS(N_BLOCKS), .TAG_W(TAG_W)) i_match (
      .valid_i(valid_q), .tags_i(tags_flat), .tag_i(req_tag), .match_o(match));

   rcd_oldest_pick #(.N_BLOCKS(N_BLOCKS), .AGE_W(IDX_W)) i_clean_pick (
      .cand_i(valid_q & ~dirty_q), .age_i(ages),
      .found_o(clean_found), .idx_o(clean_idx));

   rcd_oldest_pick #(.N_BLOCKS(N_BLOCKS), .AGE_W(IDX_W)) i_dirty_pick (
      .cand_i(valid_q & dirty_q), .age_i(ages),
      .found_o(dirty_any), .idx_o(dirty_idx));

   rcd_age_rank #(.N_BLOCKS(N_BLOCKS), .AGE_W(IDX_W)) i_rank (
      .clk(clk), .rst_n(rst_n), .touch_i(accept),
      .touch_idx_i(rsp_idx), .age_o(ages));

   always_comb begin
      hit_idx = '0;
      inv_idx = '0;
      any_inv = 1'b0;
      for (int i = 0; i < N_BLOCKS; i++) begin
         if (match[i]) hit_idx = hit_idx | IDX_W'(i);
      end
      for (int i = N_BLOCKS-1; i >= 0; i--) begin
         if (!valid_q[i]) begin
            inv_idx = IDX_W'(i);
            any_inv = 1'b1;
         end
      end
   end

   assign victim_idx  = any_inv ? inv_idx : clean_idx;
   assign have_victim = any_inv | clean_found;
   assign rsp_hit     = req_valid & (|match);
   assign rsp_idx     = rsp_hit ? hit_idx : victim_idx;
   assign rsp_stall   = req_valid & ~(|match) & ~have_victim;
   assign force_wb    = rsp_stall;
   assign accept      = req_valid & ~rsp_stall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else begin
         if (wb_done && (int'(wb_idx) < N_BLOCKS)) dirty_q[wb_idx] <= 1'b0;
         if (accept) begin
            valid_q[rsp_idx] <= 1'b1;
            if (req_write) dirty_q[rsp_idx] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (accept) tag_q[rsp_idx] <= req_tag;
   end

   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));                                                    // R2
   AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_hit && !(&valid_q)) |-> !valid_q[rsp_idx]);       // R3
   AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_write) |=> dirty_q[$past(rsp_idx)]);                  // R4
   AST_VICTIM_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_hit && !rsp_stall) |-> !(valid_q[rsp_idx] && dirty_q[rsp_idx])); // R5
   AST_STALL_ALL_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_stall |-> ((&valid_q) && (&dirty_q)));                           // R7
   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_stall |=> $stable(valid_q));                                     // R7
   AST_WB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_done && !(accept && req_write && rsp_idx == wb_idx)) |=> !dirty_q[$past(wb_idx)]); // R8
   AST_DIRTY_PICK: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_any |-> (valid_q[dirty_idx] && dirty_q[dirty_idx]));           // R9
endmodule

// File: tb/test_row_cache_directory.sv
module test_row_cache_directory;
   localparam int NB = 16;
   localparam int TW = 20;
   localparam int IW = 4;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, wb_done = 1'b0;
   logic [TW-1:0] req_tag = '0;
   logic [IW-1:0] wb_idx = '0;
   logic          rsp_hit, rsp_stall, force_wb, dirty_any;
   logic [IW-1:0] rsp_idx, dirty_idx;

   always #5 clk = ~clk;

   row_cache_directory #(.N_BLOCKS(NB), .TAG_W(TW)) i_row_cache_directory (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_tag(req_tag), .wb_done(wb_done), .wb_idx(wb_idx), .rsp_hit(rsp_hit),
      .rsp_idx(rsp_idx), .rsp_stall(rsp_stall), .force_wb(force_wb),
      .dirty_any(dirty_any), .dirty_idx(dirty_idx));

   typedef struct {
      bit    reqv;
      bit    hit;
      int    idx;
      bit    stall;
      bit    dany;
      int    didx;
      string lbl;
   } item_t;

   item_t q[$];
   int checks = 0, fails = 0;

   // reference model: recency by timestamp
   bit          m_valid [NB];
   bit          m_dirty [NB];
   logic [TW-1:0] m_tag [NB];
   int          m_stamp [NB];
   int          now = 0;

   function automatic int oldest_dirty();
      int best = -1;
      for (int i = 0; i < NB; i++)
         if (m_valid[i] && m_dirty[i] && (best < 0 || m_stamp[i] < m_stamp[best])) best = i;
      return best;
   endfunction

   task automatic chk(input bit ok, input string r, input int act, input int exp, input string what);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
      end
   endtask

   task automatic drive(input bit reqv, input logic [TW-1:0] tag, input bit wr,
                        input bit wbv, input int wbi, input string lbl);
      item_t it;
      int hit_i = -1, vic = -1, od;
      @(negedge clk);
      for (int i = 0; i < NB; i++) if (m_valid[i] && m_tag[i] == tag) hit_i = i;
      if (hit_i < 0) begin
         for (int i = NB-1; i >= 0; i--) if (!m_valid[i]) vic = i;
         if (vic < 0)
            for (int i = 0; i < NB; i++)
               if (!m_dirty[i] && (vic < 0 || m_stamp[i] < m_stamp[vic])) vic = i;
      end
      od       = oldest_dirty();
      it.reqv  = reqv;
      it.hit   = (hit_i >= 0);
      it.idx   = (hit_i >= 0) ? hit_i : vic;
      it.stall = reqv && hit_i < 0 && vic < 0;
      it.dany  = (od >= 0);
      it.didx  = od;
      it.lbl   = lbl;
      req_valid = reqv; req_tag = tag; req_write = wr;
      wb_done = wbv; wb_idx = IW'(wbi);
      q.push_back(it);
      if (wbv) m_dirty[wbi] = 1'b0;
      if (reqv && !it.stall) begin
         m_valid[it.idx] = 1'b1;
         m_tag[it.idx]   = tag;
         if (wr) m_dirty[it.idx] = 1'b1;
         now++;
         m_stamp[it.idx] = now;
      end
   endtask

   // monitor: compares outputs mid-cycle against queued expectations
   always @(negedge clk) begin
      item_t it;
      #3;
      if (q.size() > 0) begin
         it = q.pop_front();
         if (it.reqv) begin
            chk(rsp_hit == it.hit, it.lbl, rsp_hit, it.hit, "rsp_hit");
            chk(rsp_stall == it.stall, it.lbl, rsp_stall, it.stall, "rsp_stall");
            chk(force_wb == it.stall, it.lbl, force_wb, it.stall, "force_wb");
            if (!it.stall) chk(int'(rsp_idx) == it.idx, it.lbl, rsp_idx, it.idx, "rsp_idx");
         end else begin
            chk(!rsp_hit && !rsp_stall, it.lbl, rsp_stall, 0, "idle outputs");
         end
         chk(dirty_any == it.dany, it.lbl, dirty_any, it.dany, "dirty_any");
         if (it.dany) chk(int'(dirty_idx) == it.didx, it.lbl, dirty_idx, it.didx, "dirty_idx");
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      int x;
      for (int i = 0; i < NB; i++) begin
         m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = '0; m_stamp[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      drive(0, 0, 0, 0, 0, "R1");                         // reset state
      drive(1, 20'h100, 0, 0, 0, "R1");                   // first miss -> line 0
      for (int i = 1; i < NB; i++) drive(1, 20'h100 + TW'(i), 0, 0, 0, "R3");
      drive(1, 20'h105, 0, 0, 0, "R2");
      drive(1, 20'h10A, 0, 0, 0, "R2");
      drive(1, 20'h100, 0, 0, 0, "R6");
      drive(1, 20'h103, 1, 0, 0, "R4");                   // write hit -> modified
      drive(1, 20'h10C, 1, 0, 0, "R4");
      drive(0, 0, 0, 0, 0, "R9");
      drive(1, 20'h103, 0, 0, 0, "R4");                   // read hit keeps flag
      drive(0, 0, 0, 0, 0, "R9");
      drive(1, 20'h200, 0, 0, 0, "R5");                   // LRU clean victim
      drive(1, 20'h201, 0, 0, 0, "R5");
      drive(1, 20'h201, 0, 0, 0, "R10");                  // filled clean: hit
      drive(1, 20'h300, 1, 0, 0, "R10");                  // write miss fills modified
      drive(0, 0, 0, 0, 0, "R10");
      drive(1, 20'h202, 0, 0, 0, "R6");
      for (int i = 0; i < NB; i++) drive(1, m_tag[i], 1, 0, 0, "R4");
      drive(1, 20'h400, 0, 0, 0, "R7");                   // all modified -> stall
      drive(1, 20'h400, 1, 0, 0, "R7");
      drive(1, 20'h400, 0, 1, oldest_dirty(), "R8");      // still stalled this cycle
      drive(1, 20'h400, 0, 0, 0, "R8");                   // freed line now victim
      for (int i = 0; i < NB; i++) drive(0, 0, 0, 1, i, "R8");
      x = 7;
      drive(1, m_tag[x], 1, 1, x, "R8");                  // write beats completion
      drive(0, 0, 0, 0, 0, "R8");
      drive(0, 0, 0, 1, x, "R8");
      drive(0, 0, 0, 0, 0, "R9");
      for (int n = 0; n < 800; n++) begin
         int od;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         od = oldest_dirty();
         drive(lfsr[0] | lfsr[1], 20'h500 + TW'(int'(lfsr[15:4]) % 24), lfsr[2],
               (od >= 0) && lfsr[3] && lfsr[5], (od >= 0) ? od : 0, "R5");
      end
      @(negedge clk);
      req_valid = 0; wb_done = 0;
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule